// File: doc/BRIEF.md
# Processor Parallel Bus Slave Buffer

This block lets a host processor reach a word buffer inside the programmable logic over an asynchronous external memory bus. The host drives active-low chip select, write enable and output enable, a 16-bit address and a 32-bit data word. Every access is a full word, so there are no byte-lane inputs. The shared data pins are not built here. The block instead offers a data-in word, a data-out word and a drive-enable bit. The top level uses these to build the tri-state pad.

Inside sits a 1024 x 32 true dual-port buffer. The bus side uses one port. Internal logic uses the other, with its own write strobe, address, write data and registered read data. All bus inputs are sampled on one system clock. The three strobes pass through a two-stage synchronizer before any decision is made. A write commits exactly once, on the synchronized falling edge of write enable. A read drives the bus only while chip select and output enable are both held low.

Top module: `pbus_slave_buf`

## Requirements
- R1: After synchronous active-high reset, `bus_dout_en` is 0 and stays 0 while the bus is idle (all strobes high).
- R2: While chip select is high, `bus_dout_en` stays 0, even with output enable low, and no write takes place on a write-enable falling edge.
- R3: While write enable and output enable are both low, the block neither drives the bus nor writes the buffer.
- R4: With chip select low, a falling edge on write enable writes `bus_din` into the buffer once. The data written is the value present two clocks after the fall. Later changes to `bus_din` while write enable stays low have no effect.
- R5: While chip select and output enable are low and write enable is high, `bus_dout_en` is 1 and `bus_dout` shows the buffer word at the current address. The output follows address changes, lagging the raw address by one clock.
- R6: Once chip select or output enable returns high, `bus_dout_en` is 0 by the third rising clock edge after the change.
- R7: Only `bus_addr[9:0]` selects the word. Addresses that differ only in bits 15..10 reach the same word.
- R8: The internal port writes on `int_we` at a rising edge. It returns `int_rdata` for `int_addr` one clock later and works independently of bus traffic.
- R9: When the bus side and the internal side write the same word in the same clock, the bus data is the value stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_we_n | input | 1 | Host write enable, active low |
| bus_oe_n | input | 1 | Host output enable, active low |
| bus_addr | input | 16 | Host address; low 10 bits index the buffer |
| bus_din | input | 32 | Word arriving from the data pins |
| bus_dout | output | 32 | Word to place on the data pins |
| bus_dout_en | output | 1 | Drive enable for the data pins |
| int_we | input | 1 | Internal port write strobe |
| int_addr | input | 10 | Internal port word index |
| int_wdata | input | 32 | Internal port write data |
| int_rdata | output | 32 | Internal port read data, one clock latency |

## Verification
Two events can land in the same clock: a bus write commit and an internal write to the same word. The bench provokes this by timing `int_we` to the clock in which the synchronized write-enable fall commits. It computes that clock from the two synchronizer stages plus the edge detector. It then reads the word back through the internal port and expects the bus value. A second overlap, an illegal strobe pair, is provoked by lowering write enable while output enable is already low. It is judged by the drive enable staying low and the target word keeping its earlier content.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int unsigned BUS_ADDR_W = 16;
  localparam int unsigned BUF_IDX_W  = 10;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned SYNC_DEPTH = 2;

  // synchronized strobe levels (active low, as on the pins)
  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/pbus_strobe_ctl.sv
module pbus_strobe_ctl
  import pbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  strobe_t stb,       // synchronized strobes
  output logic    wr_fire,   // single-cycle write commit
  output logic    rd_active, // legal read in progress
  output logic    illegal    // write and output enable both low
);
  logic we_prev;

  always_ff @(posedge clk) begin
    if (rst) we_prev <= 1'b1;
    else     we_prev <= stb.we_n;
  end

  function automatic logic is_fall(logic prev, logic now);
    return prev & ~now;
  endfunction

  assign illegal   = ~stb.we_n & ~stb.oe_n;
  assign wr_fire   = is_fall(we_prev, stb.we_n) & ~stb.cs_n & stb.oe_n;
  assign rd_active = ~stb.cs_n & ~stb.oe_n & stb.we_n;

  assert_single_commit_R4: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> !wr_fire);
  assert_no_write_illegal_R3: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !wr_fire);
  assert_no_write_deselected_R2: assert property (@(posedge clk) disable iff (rst)
    stb.cs_n |-> !wr_fire);
endmodule

// File: rtl/pbus_dpram.sv
module pbus_dpram #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  // bus-side port
  input  logic              a_we,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_wd,
  output logic [DATA_W-1:0] a_rd,
  // internal port
  input  logic              b_we,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [DATA_W-1:0] b_wd,
  output logic [DATA_W-1:0] b_rd
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // later assignment wins: bus side has priority on a shared word
  always_ff @(posedge clk) begin
    if (b_we) mem[b_idx] <= b_wd;
    if (a_we) mem[a_idx] <= a_wd;
  end

  always_ff @(posedge clk) begin
    a_rd <= mem[a_idx];
    b_rd <= mem[b_idx];
  end

  assert_bus_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (a_we && b_we && a_idx == b_idx) |=> mem[$past(a_idx)] == $past(a_wd));
endmodule

// File: rtl/pbus_slave_buf.sv
module pbus_slave_buf
  import pbus_pkg::*;
#(
  parameter int unsigned ADDR_W = BUS_ADDR_W,
  parameter int unsigned IDX_W  = BUF_IDX_W,
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned SYNC_N = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  input  logic              int_we,
  input  logic [IDX_W-1:0]  int_addr,
  input  logic [DATA_W-1:0] int_wdata,
  output logic [DATA_W-1:0] int_rdata
);
  function automatic logic [IDX_W-1:0] buf_index(logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  logic    unused_addr_hi;
  assign unused_addr_hi = ^bus_addr[ADDR_W-1:IDX_W];

  strobe_t stb_raw, stb_s;
  logic    wr_fire, rd_active, illegal;
  logic    dout_en_q;

  assign stb_raw = '{cs_n: bus_cs_n, we_n: bus_we_n, oe_n: bus_oe_n};

  pbus_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(STROBE_IDLE)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (stb_raw),
    .q_sync  (stb_s)
  );

  pbus_strobe_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb_s),
    .wr_fire   (wr_fire),
    .rd_active (rd_active),
    .illegal   (illegal)
  );

  pbus_dpram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_buf (
    .clk   (clk),
    .rst   (rst),
    .a_we  (wr_fire),
    .a_idx (buf_index(bus_addr)),
    .a_wd  (bus_din),
    .a_rd  (bus_dout),
    .b_we  (int_we),
    .b_idx (int_addr),
    .b_wd  (int_wdata),
    .b_rd  (int_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) dout_en_q <= 1'b0;
    else     dout_en_q <= rd_active;
  end

  assign bus_dout_en = dout_en_q;

  assert_release_deselected_R2: assert property (@(posedge clk) disable iff (rst)
    stb_s.cs_n |=> !bus_dout_en);
  assert_no_drive_illegal_R3: assert property (@(posedge clk) disable iff (rst)
    illegal |=> !bus_dout_en);
  assert_drive_on_read_R5: assert property (@(posedge clk) disable iff (rst)
    rd_active |=> bus_dout_en);
  assert_drop_on_release_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(stb_s.cs_n) || $rose(stb_s.oe_n)) |=> !bus_dout_en);
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> !bus_dout_en);
endmodule

// File: tb/pbus_slave_buf_bench.sv
module pbus_slave_buf_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        cs_n, we_n, oe_n;
  logic [15:0] addr;
  logic [31:0] din;
  logic [31:0] dout;
  logic        dout_en;
  logic        iwe;
  logic [9:0]  iaddr;
  logic [31:0] iwd;
  logic [31:0] ird;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pbus_slave_buf u_pbus_slave_buf (
    .clk(clk), .rst(rst),
    .bus_cs_n(cs_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
    .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_dout_en(dout_en),
    .int_we(iwe), .int_addr(iaddr), .int_wdata(iwd), .int_rdata(ird)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic int_write(input logic [9:0] a, input logic [31:0] d);
    iaddr = a; iwd = d; iwe = 1'b1;
    cyc(1);
    iwe = 1'b0;
  endtask

  task automatic int_read(input logic [9:0] a, output logic [31:0] d);
    iaddr = a;
    cyc(1);
    d = ird;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    addr = a; din = d; cs_n = 1'b0; we_n = 1'b0;
    cyc(5);
    we_n = 1'b1;
    cyc(4);
    cs_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_reset_R1;
    cyc(6);
    check(dout_en === 1'b0, "R1 idle drive", {31'd0, dout_en}, 32'd0);
  endtask

  task automatic t_internal_R8;
    logic [31:0] r;
    int_write(10'd5, 32'hA5A5_0005);
    int_write(10'd6, 32'h0000_0606);
    int_read(10'd5, r);
    check(r === 32'hA5A5_0005, "R8 int read 5", r, 32'hA5A5_0005);
    int_read(10'd6, r);
    check(r === 32'h0000_0606, "R8 int read 6", r, 32'h0000_0606);
  endtask

  task automatic t_read_R5;
    cs_n = 1'b0; oe_n = 1'b0; addr = 16'd5;
    cyc(3);
    check(dout_en === 1'b1, "R5 drive", {31'd0, dout_en}, 32'd1);
    check(dout === 32'hA5A5_0005, "R5 data", dout, 32'hA5A5_0005);
    addr = 16'd6;
    cyc(1);
    check(dout === 32'h0000_0606, "R5 follows addr", dout, 32'h0000_0606);
    oe_n = 1'b1;
    cyc(3);
    check(dout_en === 1'b0, "R6 drop on oe", {31'd0, dout_en}, 32'd0);
    oe_n = 1'b0;
    cyc(4);
    cs_n = 1'b1;
    cyc(3);
    check(dout_en === 1'b0, "R6 drop on cs", {31'd0, dout_en}, 32'd0);
    oe_n = 1'b1;
    cyc(2);
  endtask

  task automatic t_write_R4;
    logic [31:0] r;
    addr = 16'd20; din = 32'h1111_2222; cs_n = 1'b0; we_n = 1'b0;
    cyc(5);
    din = 32'hDEAD_BEEF;
    cyc(5);
    we_n = 1'b1;
    cyc(3);
    cs_n = 1'b1;
    cyc(3);
    int_read(10'd20, r);
    check(r === 32'h1111_2222, "R4 single commit", r, 32'h1111_2222);
  endtask

  task automatic t_deselected_R2;
    logic [31:0] r;
    oe_n = 1'b0; addr = 16'd5;
    cyc(4);
    check(dout_en === 1'b0, "R2 oe while deselected", {31'd0, dout_en}, 32'd0);
    oe_n = 1'b1;
    cyc(3);
    addr = 16'd20; din = 32'h7777_7777; we_n = 1'b0;
    cyc(5);
    we_n = 1'b1;
    cyc(3);
    int_read(10'd20, r);
    check(r === 32'h1111_2222, "R2 write while deselected", r, 32'h1111_2222);
  endtask

  task automatic t_illegal_R3;
    logic [31:0] r;
    addr = 16'd6; cs_n = 1'b0; oe_n = 1'b0;
    cyc(4);
    din = 32'h9999_0000; we_n = 1'b0;
    cyc(4);
    check(dout_en === 1'b0, "R3 no drive", {31'd0, dout_en}, 32'd0);
    we_n = 1'b1; oe_n = 1'b1;
    cyc(3);
    cs_n = 1'b1;
    cyc(3);
    int_read(10'd6, r);
    check(r === 32'h0000_0606, "R3 no write", r, 32'h0000_0606);
  endtask

  task automatic t_alias_R7;
    logic [31:0] r;
    bus_write(16'hFC07, 32'hCAFE_0007);
    int_read(10'd7, r);
    check(r === 32'hCAFE_0007, "R7 alias write", r, 32'hCAFE_0007);
    cs_n = 1'b0; oe_n = 1'b0; addr = 16'h0407;
    cyc(3);
    check(dout === 32'hCAFE_0007, "R7 alias read", dout, 32'hCAFE_0007);
    cs_n = 1'b1; oe_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_collide_R9;
    logic [31:0] r;
    addr = 16'd30; din = 32'hB0B0_B0B0; cs_n = 1'b0; we_n = 1'b0;
    // sync stage 1 at edge 1, stage 2 at edge 2, commit at edge 3
    repeat (2) @(posedge clk);
    @(negedge clk);
    iaddr = 10'd30; iwd = 32'h1E1E_1E1E; iwe = 1'b1;
    cyc(1);
    iwe = 1'b0;
    cyc(3);
    we_n = 1'b1;
    cyc(3);
    cs_n = 1'b1;
    cyc(3);
    int_read(10'd30, r);
    check(r === 32'hB0B0_B0B0, "R9 bus wins", r, 32'hB0B0_B0B0);
    int_write(10'd31, 32'h3131_3131);
    bus_write(16'd32, 32'h3232_3232);
    int_read(10'd31, r);
    check(r === 32'h3131_3131, "R8 independent of bus", r, 32'h3131_3131);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr = '0; din = '0; iwe = 1'b0; iaddr = '0; iwd = '0;
    cyc(4);
    rst = 1'b0;
    t_reset_R1();
    t_internal_R8();
    t_read_R5();
    t_write_R4();
    t_deselected_R2();
    t_illegal_R3();
    t_alias_R7();
    t_collide_R9();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule